// File: doc/BRIEF.md
# Oversampled Serial Character Receiver

This block turns an asynchronous serial line into parallel characters. A free-running tick runs at sixteen times the bit rate and acts as a clock enable. On each tick the block samples the line. After the line falls, a start bit is confirmed by a majority vote near the middle of the bit. The block then collects a character of five to nine data bits, least significant bit first. An optional parity bit follows, and the first stop bit is checked. Each finished character goes into a two-entry buffer together with its own framing and parity error flags.

A consumer sees the oldest buffered character on the data output while the receive-complete output is high. It removes that character with a one-cycle read strobe. A separate pulse marks every confirmed start bit. A sticky overflow flag records a character that was lost because the buffer was full. Dropping the receive enable stops reception, empties the buffer and clears the overflow flag. Character size and parity settings must stay steady while the receiver is enabled.

Top module: `serial_rx`

## Requirements
- R1: While reset is asserted, and after it is released, `rx_done`, `rx_start`, `ferr`, `perr` and `ovf` are 0.
- R2: `char_sel` picks the character length: 0 gives 8 bits, 1 gives 9 bits, and 5, 6 and 7 give 5, 6 and 7 bits. The first data bit on the line lands in `rx_word[0]`, and bits above the character length read as 0.
- R3: The line is sampled at ticks 7, 8 and 9 after the tick that first saw it low. If the majority of those three samples is high, the start is discarded. No pulse and no character result from it.
- R4: `rx_start` is high for exactly one clock cycle for each confirmed start bit.
- R5: With `par_en` = 1, a parity bit follows the data. With `par_odd` = 0 the data bits plus the parity bit must hold an even number of ones. With `par_odd` = 1 they must hold an odd number. A mismatch sets `perr` for that character.
- R6: If the first stop bit is sampled low, the character is still stored, with `ferr` = 1. `ferr` and `perr` belong to the character shown on `rx_word` and are 0 whenever `rx_done` is 0.
- R7: The buffer holds two characters and returns them in arrival order. A character that completes while the buffer is full is dropped, and `ovf` is set. `ovf` stays at 1 while `rx_en` stays at 1.
- R8: If a character completes in the same cycle as a read strobe while the buffer is full, the new character is accepted and `ovf` is not set.
- R9: While `rx_en` = 0, the buffer is empty, `ovf` is 0 and line activity neither produces a character nor raises `rx_start`.
- R10: The unused `char_sel` codes 2, 3 and 4 are handled as 8-bit characters.
- R11: With `par_en` = 0, no parity bit is expected and `perr` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Sampling enable, sixteen per bit time |
| rx_en | input | 1 | Receive enable; 0 stops reception and flushes the buffer |
| rxd | input | 1 | Serial line, idle high |
| char_sel | input | 3 | Character length code |
| par_en | input | 1 | Parity bit expected |
| par_odd | input | 1 | 0 for even parity, 1 for odd parity |
| rd_stb | input | 1 | Removes the oldest buffered character |
| rx_word | output | 9 | Oldest buffered character |
| rx_done | output | 1 | At least one character is buffered |
| rx_start | output | 1 | One-cycle pulse on a confirmed start bit |
| ferr | output | 1 | Framing error of the shown character |
| perr | output | 1 | Parity error of the shown character |
| ovf | output | 1 | Sticky lost-character flag |

## Verification
The delicate coincidence is a character completing in the same clock edge in which a read strobe removes an entry from a full buffer. In that edge, overflow and acceptance compete. The bench first measures the delay from the start edge to the rise of `rx_done` with a tick phase held fixed. It then fills the buffer and sends a third character with the same alignment. The read strobe is placed on exactly the measured completion edge. The outcome is judged from the ports: `ovf` must stay 0, and reading must return the second and third characters in order, with nothing after them.

// File: rtl/srx_pkg.sv
package srx_pkg;

  localparam int unsigned MAX_BITS = 9;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  // Character length from the size code; unused codes fall back to 8 (R10)
  function automatic logic [3:0] char_bits(input logic [2:0] sel);
    logic [3:0] n;
    case (sel)
      3'd1:    n = 4'd9;
      3'd5:    n = 4'd5;
      3'd6:    n = 4'd6;
      3'd7:    n = 4'd7;
      default: n = 4'd8;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int unsigned STAGES = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/srx_framer.sv
module srx_framer
  import srx_pkg::*;
#(
  parameter int unsigned DW  = 9,
  parameter int unsigned OSR = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          tick,
  input  logic          rxd,
  input  logic [3:0]    nbits,
  input  logic          par_en,
  input  logic          par_odd,
  output logic          start_o,
  output logic          push_o,
  output logic [DW-1:0] data_o,
  output logic          ferr_o,
  output logic          perr_o
);

  localparam int unsigned PHW   = $clog2(OSR);
  localparam logic [PHW-1:0] SMP_A = PHW'(OSR / 2 - 1);
  localparam logic [PHW-1:0] SMP_B = PHW'(OSR / 2);
  localparam logic [PHW-1:0] SMP_C = PHW'(OSR / 2 + 1);
  localparam logic [PHW-1:0] PH_LAST = PHW'(OSR - 1);

  rx_state_e      state_q, state_d;
  logic [PHW-1:0] ph_q, ph_d, ph_inc;
  logic [3:0]     bidx_q, bidx_d;
  logic           vote_a_q, vote_a_d;
  logic           vote_b_q, vote_b_d;
  logic [DW-1:0]  data_q, data_d;
  logic           ferr_q, ferr_d;
  logic           perr_q, perr_d;
  logic           start_q, start_d;
  logic           push_q, push_d;
  logic           maj;

  always_comb begin
    state_d  = state_q;
    ph_d     = ph_q;
    bidx_d   = bidx_q;
    vote_a_d = vote_a_q;
    vote_b_d = vote_b_q;
    data_d   = data_q;
    ferr_d   = ferr_q;
    perr_d   = perr_q;
    start_d  = 1'b0;
    push_d   = 1'b0;
    ph_inc   = ph_q + PHW'(1);
    maj      = (vote_a_q & vote_b_q) | (vote_a_q & rxd) | (vote_b_q & rxd);

    if (!en) begin
      state_d = ST_IDLE;
      ph_d    = '0;
    end else if (tick) begin
      if (state_q == ST_IDLE) begin
        if (!rxd) begin
          state_d = ST_START;
          ph_d    = '0;
          bidx_d  = '0;
          data_d  = '0;
          ferr_d  = 1'b0;
          perr_d  = 1'b0;
        end
      end else begin
        ph_d = ph_inc;
        if (ph_inc == SMP_A) vote_a_d = rxd;
        if (ph_inc == SMP_B) vote_b_d = rxd;
        if (ph_inc == SMP_C) begin
          case (state_q)
            ST_START: begin
              if (maj) state_d = ST_IDLE;   // false start (R3)
              else     start_d = 1'b1;      // confirmed (R4)
            end
            ST_DATA: begin
              for (int i = 0; i < DW; i++) begin
                if (bidx_q == 4'(i)) data_d[i] = maj;
              end
            end
            ST_PAR: begin
              perr_d = (((^data_q) ^ maj) != par_odd);
            end
            ST_STOP: begin
              ferr_d  = !maj;
              push_d  = 1'b1;
              state_d = ST_IDLE;
            end
            default: ;
          endcase
        end
        if (ph_q == PH_LAST) begin
          case (state_q)
            ST_START: state_d = ST_DATA;
            ST_DATA: begin
              if (bidx_q == nbits - 4'd1) state_d = par_en ? ST_PAR : ST_STOP;
              else                        bidx_d  = bidx_q + 4'd1;
            end
            ST_PAR:  state_d = ST_STOP;
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      ph_q     <= '0;
      bidx_q   <= '0;
      vote_a_q <= 1'b1;
      vote_b_q <= 1'b1;
      data_q   <= '0;
      ferr_q   <= 1'b0;
      perr_q   <= 1'b0;
      start_q  <= 1'b0;
      push_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      ph_q     <= ph_d;
      bidx_q   <= bidx_d;
      vote_a_q <= vote_a_d;
      vote_b_q <= vote_b_d;
      data_q   <= data_d;
      ferr_q   <= ferr_d;
      perr_q   <= perr_d;
      start_q  <= start_d;
      push_q   <= push_d;
    end
  end

  assign start_o = start_q;
  assign push_o  = push_q;
  assign data_o  = data_q;
  assign ferr_o  = ferr_q;
  assign perr_o  = perr_q;

endmodule

// File: rtl/srx_buf.sv
module srx_buf #(
  parameter int unsigned W     = 11,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         nonempty,
  output logic         ovf
);

  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] P_LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] C_FULL = CW'(DEPTH);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ovf_q, ovf_d;
  logic          pop_ok, push_ok;

  always_comb begin
    pop_ok  = pop && (cnt_q != '0);
    push_ok = push && ((cnt_q != C_FULL) || pop_ok);   // R8
    wp_d    = wp_q;
    rp_d    = rp_q;
    cnt_d   = cnt_q;
    ovf_d   = ovf_q;
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
      ovf_d = 1'b0;                                    // R9
    end else begin
      if (push_ok) wp_d = (wp_q == P_LAST) ? '0 : wp_q + PW'(1);
      if (pop_ok)  rp_d = (rp_q == P_LAST) ? '0 : rp_q + PW'(1);
      if (push_ok && !pop_ok)      cnt_d = cnt_q + CW'(1);
      else if (pop_ok && !push_ok) cnt_d = cnt_q - CW'(1);
      if (push && !push_ok) ovf_d = 1'b1;              // R7
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!flush && push_ok && (wp_q == PW'(g))) mem_q[g] <= din;
    end
  end

  assign nonempty = (cnt_q != '0);
  assign dout     = nonempty ? mem_q[rp_q] : '0;
  assign ovf      = ovf_q;

endmodule

// File: rtl/serial_rx.sv
module serial_rx
  import srx_pkg::*;
#(
  parameter int unsigned DW        = MAX_BITS,
  parameter int unsigned OSR       = 16,
  parameter int unsigned BUF_DEPTH = 2,
  parameter int unsigned SYNC_LEN  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick16,
  input  logic          rx_en,
  input  logic          rxd,
  input  logic [2:0]    char_sel,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic          rd_stb,
  output logic [DW-1:0] rx_word,
  output logic          rx_done,
  output logic          rx_start,
  output logic          ferr,
  output logic          perr,
  output logic          ovf
);

  localparam int unsigned EW = DW + 2;

  logic          rst_l;
  logic          rxd_s;
  logic          fr_push, fr_ferr, fr_perr;
  logic [DW-1:0] fr_data;
  logic [EW-1:0] buf_in, buf_out;
  logic          buf_nonempty;

  // Reset: asserts at once, leaves reset on a clock edge
  srx_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_l)
  );

  srx_sync #(.STAGES(SYNC_LEN), .RST_VAL(1'b1)) u_line (
    .clk(clk), .rst_n(rst_l), .d(rxd), .q(rxd_s)
  );

  srx_framer #(.DW(DW), .OSR(OSR)) u_framer (
    .clk(clk), .rst_n(rst_l), .en(rx_en), .tick(tick16), .rxd(rxd_s),
    .nbits(char_bits(char_sel)), .par_en(par_en), .par_odd(par_odd),
    .start_o(rx_start), .push_o(fr_push), .data_o(fr_data),
    .ferr_o(fr_ferr), .perr_o(fr_perr)
  );

  assign buf_in = {fr_ferr, fr_perr, fr_data};

  srx_buf #(.W(EW), .DEPTH(BUF_DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_l), .flush(!rx_en), .push(fr_push), .din(buf_in),
    .pop(rd_stb), .dout(buf_out), .nonempty(buf_nonempty), .ovf(ovf)
  );

  assign rx_done = buf_nonempty;
  assign rx_word = buf_out[DW-1:0];
  assign perr    = buf_out[DW];
  assign ferr    = buf_out[DW+1];

endmodule

// File: rtl/serial_rx_chk.sv
module serial_rx_chk #(
  parameter int unsigned DW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_en,
  input logic          rd_stb,
  input logic          rx_start,
  input logic          rx_done,
  input logic [DW-1:0] rx_word,
  input logic          ferr,
  input logic          perr,
  input logic          ovf
);

  p_start_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_start |=> !rx_start);

  p_flags_need_char_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ferr || perr) |-> rx_done);

  p_hold_head_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && rx_done && !rd_stb) |=>
      (rx_done && $stable(rx_word) && $stable(ferr) && $stable(perr)));

  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && ovf) |=> ovf);

  p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (!rx_done && !ovf));

  p_quiet_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !rx_start);

endmodule

bind serial_rx serial_rx_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rd_stb(rd_stb),
  .rx_start(rx_start), .rx_done(rx_done), .rx_word(rx_word),
  .ferr(ferr), .perr(perr), .ovf(ovf)
);

// File: tb/serial_rx_test.sv
module serial_rx_test;

  localparam int BIT = 64;  // 16 ticks of 4 clocks

  logic       clk = 1'b0;
  logic       rst_n, rx_en, rxd, par_en, par_odd, rd_stb;
  logic [2:0] char_sel;
  logic [8:0] rx_word;
  logic       rx_done, rx_start, ferr, perr, ovf, tick16;
  logic [1:0] tk = 2'd0;
  int         cyc = 0;
  int         starts = 0;
  int         n_chk = 0;
  int         n_bad = 0;

  always #5 clk = ~clk;
  always @(posedge clk) tk <= tk + 2'd1;
  always @(posedge clk) cyc <= cyc + 1;
  assign tick16 = (tk == 2'd0);
  always @(negedge clk) if (rx_start === 1'b1) starts++;

  serial_rx uut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_en(rx_en), .rxd(rxd),
    .char_sel(char_sel), .par_en(par_en), .par_odd(par_odd), .rd_stb(rd_stb),
    .rx_word(rx_word), .rx_done(rx_done), .rx_start(rx_start),
    .ferr(ferr), .perr(perr), .ovf(ovf)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_frame(input logic [8:0] d, input int nb, input bit pen,
                            input bit podd, input bit pflip, input bit stop_hi);
    logic p;
    p = podd ^ pflip;
    rxd = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      rxd = d[i];
      p   = p ^ d[i];
      repeat (BIT) @(negedge clk);
    end
    if (pen) begin
      rxd = p;
      repeat (BIT) @(negedge clk);
    end
    rxd = stop_hi;
    repeat (BIT) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * BIT) @(negedge clk);
  endtask

  task automatic pop();
    @(negedge clk) rd_stb = 1'b1;
    @(negedge clk) rd_stb = 1'b0;
  endtask

  task automatic align();
    @(negedge clk);
    while (tk != 2'd0) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 done in reset", rx_done, 0);
    chk("R1 start in reset", rx_start, 0);
    chk("R1 ovf in reset", ovf, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 flags after reset", {ferr, perr, ovf, rx_done}, 0);
    rx_en = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_basic8();
    int s0 = starts;
    char_sel = 3'd0; par_en = 1'b0;
    send_frame(9'h0A5, 8, 0, 0, 0, 1);
    chk("R2 8-bit word", rx_word, 'h0A5);
    chk("R2 8-bit done", rx_done, 1);
    chk("R11 no parity perr", perr, 0);
    chk("R4 one start pulse", starts - s0, 1);
    pop();
    chk("R2 empty after read", rx_done, 0);
  endtask

  task automatic t_sizes();
    char_sel = 3'd5;
    send_frame(9'h015, 5, 0, 0, 0, 1);
    chk("R2 5-bit word", rx_word, 'h015);
    pop();
    char_sel = 3'd1;
    send_frame(9'h1C3, 9, 0, 0, 0, 1);
    chk("R2 9-bit word", rx_word, 'h1C3);
    pop();
    char_sel = 3'd6;
    send_frame(9'h02D, 6, 0, 0, 0, 1);
    chk("R2 6-bit word", rx_word, 'h02D);
    pop();
    char_sel = 3'd3;
    send_frame(9'h0C3, 8, 0, 0, 0, 1);
    chk("R10 code 3 as 8-bit", rx_word, 'h0C3);
    pop();
    char_sel = 3'd0;
  endtask

  task automatic t_parity();
    char_sel = 3'd7; par_en = 1'b1; par_odd = 1'b0;
    send_frame(9'h05A, 7, 1, 0, 0, 1);
    chk("R5 even good word", rx_word, 'h05A);
    chk("R5 even good perr", perr, 0);
    pop();
    par_odd = 1'b1;
    send_frame(9'h031, 7, 1, 1, 0, 1);
    chk("R5 odd good perr", perr, 0);
    pop();
    send_frame(9'h031, 7, 1, 1, 1, 1);
    chk("R5 odd bad perr", perr, 1);
    chk("R5 odd bad word", rx_word, 'h031);
    pop();
    par_odd = 1'b0;
    send_frame(9'h05A, 7, 1, 0, 1, 1);
    chk("R5 even bad perr", perr, 1);
    pop();
    chk("R6 perr cleared when empty", perr, 0);
    par_en = 1'b0; char_sel = 3'd0;
  endtask

  task automatic t_frame_err();
    int s0 = starts;
    send_frame(9'h03C, 8, 0, 0, 0, 0);
    chk("R6 ferr set", ferr, 1);
    chk("R6 word kept", rx_word, 'h03C);
    chk("R6 ferr with done", rx_done, 1);
    pop();
    chk("R6 no extra char", rx_done, 0);
    chk("R6 ferr cleared", ferr, 0);
    chk("R3 low stop not a start", starts - s0, 1);
  endtask

  task automatic t_glitch();
    int s0 = starts;
    rxd = 1'b0;
    repeat (16) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * BIT) @(negedge clk);
    chk("R3 glitch no pulse", starts - s0, 0);
    chk("R3 glitch no char", rx_done, 0);
    send_frame(9'h081, 8, 0, 0, 0, 1);
    chk("R3 frame after glitch", rx_word, 'h081);
    pop();
  endtask

  task automatic t_overlap();
    int t0, dly;
    align();
    t0 = cyc;
    dly = -1;
    fork
      send_frame(9'h011, 8, 0, 0, 0, 1);
      begin
        for (int k = 0; k < 2000 && dly < 0; k++) begin
          @(negedge clk);
          if (rx_done) dly = cyc - t0;
        end
      end
    join
    send_frame(9'h022, 8, 0, 0, 0, 1);
    align();
    t0 = cyc;
    fork
      send_frame(9'h033, 8, 0, 0, 0, 1);
      begin
        while (cyc != t0 + dly - 1) @(negedge clk);
        rd_stb = 1'b1;
        @(negedge clk) rd_stb = 1'b0;
      end
    join
    chk("R8 no overflow on same-cycle read", ovf, 0);
    chk("R8 head is second", rx_word, 'h022);
    pop();
    chk("R8 new char kept", rx_word, 'h033);
    pop();
    chk("R8 drained", rx_done, 0);
  endtask

  task automatic t_overflow();
    send_frame(9'h041, 8, 0, 0, 0, 1);
    send_frame(9'h042, 8, 0, 0, 0, 1);
    chk("R7 no ovf at two", ovf, 0);
    send_frame(9'h043, 8, 0, 0, 0, 1);
    chk("R7 ovf set", ovf, 1);
    chk("R7 oldest first", rx_word, 'h041);
    pop();
    chk("R7 second kept", rx_word, 'h042);
    pop();
    chk("R7 third dropped", rx_done, 0);
    chk("R7 ovf sticky", ovf, 1);
  endtask

  task automatic t_flush();
    int s0;
    send_frame(9'h055, 8, 0, 0, 0, 1);
    chk("R9 char before flush", rx_done, 1);
    @(negedge clk) rx_en = 1'b0;
    @(negedge clk);
    chk("R9 buffer flushed", rx_done, 0);
    chk("R9 ovf cleared", ovf, 0);
    s0 = starts;
    send_frame(9'h066, 8, 0, 0, 0, 1);
    chk("R9 no start while off", starts - s0, 0);
    chk("R9 no char while off", rx_done, 0);
    rx_en = 1'b1;
    repeat (BIT) @(negedge clk);
    chk("R9 still empty on re-enable", rx_done, 0);
  endtask

  initial begin
    rst_n = 1'b0; rx_en = 1'b0; rxd = 1'b1; rd_stb = 1'b0;
    char_sel = 3'd0; par_en = 1'b0; par_odd = 1'b0;
    repeat (5) @(negedge clk);
    t_reset();
    t_basic8();
    t_sizes();
    t_parity();
    t_frame_err();
    t_glitch();
    t_overlap();
    t_overflow();
    t_flush();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule